// File: doc/BRIEF.md
# Clock Frequency Measurement Checker

This block checks that one or more monitored clocks run at roughly the expected rate. It works by counting the rising edges of each monitored clock that fall inside one period of a slow reference clock. That reference clock is always on. At every rising edge of the reference, the count for the window that just closed is compared against a programmable window made of a low and a high threshold. A count outside that window raises a sticky measurement error for that clock. A clock that produces no edges at all for two windows in a row raises a separate, sticky timeout error. Any sticky error drives the recoverable alert output.

The monitored clocks and the reference clock enter as asynchronous signals. Each one passes through a two-flop synchronizer and an edge detector running on the system clock `clk_i`. The counting and the checks are therefore sampled versions of the real edges, which requires `clk_i` to be well above every monitored frequency.

Each clock has a small state machine with three named states:
- `CH_OFF`: checking is disabled.
- `CH_SYNC`: checking is enabled and the block waits for the first reference edge, so that it starts on a whole window.
- `CH_RUN`: every reference edge closes a window and evaluates it.

The transitions are:
- enable seen moves `CH_OFF` to `CH_SYNC`.
- the first reference rise moves `CH_SYNC` to `CH_RUN`.
- enable lost moves `CH_SYNC` or `CH_RUN` back to `CH_OFF`.

Configuration is written through a simple write port and read back through a combinational read port. A lock bit can only be cleared, and once cleared it freezes the enable and threshold settings.

Top module: `clkmeas_top`

## Requirements
- R1: After reset, the read values are as follows. Address 0 (lock, bit 0) reads 1. Address 1 (enables) reads 4'b1001 in every 4-bit slot. Address 2 (errors) reads 0. Address 3+i (thresholds of clock i) reads high = RATIO+10 in bits [W-1:0] and low = RATIO-10 in bits [2W-1:W], where W = bit length of RATIO plus one. `alert_o` is 0.
- R2: Clock i is checked only while its enable slot, bits [4i+3:4i] of address 1, holds exactly 4'b0110. Any other value, such as 4'b0111, disables it, and no error bit of that clock is set.
- R3: A closed window whose count c satisfies low <= c <= high sets no error bit.
- R4: A count above the high threshold sets measurement error bit i of address 2.
- R5: A count below the low threshold sets measurement error bit i of address 2.
- R6: A zero count in two consecutive evaluated windows sets timeout error bit NUM_CLK+i of address 2. A single zero window does not set it.
- R7: Error bits are sticky. Writing address 2 clears exactly the bits written as 1 and leaves the others set.
- R8: `alert_o` is 1 exactly when any error bit is set.
- R9: The lock bit is cleared by writing 0 and cannot be set again by writing 1. While it is clear, writes to the enable and threshold addresses leave them unchanged.
- R10: After enabling, the partial window up to the first reference rise is not evaluated, whatever its count.
- R11: The window count saturates at 2^W-1, so a very fast clock still compares as that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all other inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_clk_i | input | NUM_CLK | Monitored clocks, asynchronous |
| ref_clk_i | input | 1 | Slow always-on reference clock, asynchronous |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| alert_o | output | 1 | Recoverable alert, high while any error is set |

## Verification
The assertions assume the following about the inputs:
- Every monitored and reference pulse stays high and low for at least two `clk_i` cycles, so the synchronizers see each edge exactly once.
- Writes never land in the same cycle as a window evaluation that they would race.

The stimulus holds each level for two system cycles. It places all monitored pulses of a window strictly between two reference pulses. It performs every register write and read in quiet gaps between windows.

// File: rtl/clkmeas_pkg.sv
package clkmeas_pkg;
    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_SYNC = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

    localparam logic [3:0] MB_TRUE  = 4'b0110;
    localparam logic [3:0] MB_FALSE = 4'b1001;

    localparam int ADDR_LOCK = 0;
    localparam int ADDR_EN   = 1;
    localparam int ADDR_ERR  = 2;
    localparam int ADDR_THR0 = 3;
endpackage

// File: rtl/clkmeas_edge.sv
module clkmeas_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic [2:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[1:0], async_i};
    end

    assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/clkmeas_chan.sv
module clkmeas_chan
    import clkmeas_pkg::*;
#(
    parameter int THR_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [THR_W-1:0] lo_i,
    input  logic [THR_W-1:0] hi_i,
    input  logic             mon_rise_i,
    input  logic             ref_rise_i,
    output logic             meas_hit_o,
    output logic             tmo_hit_o
);
    localparam logic [THR_W-1:0] CNT_MAX = '1;

    ch_state_e        state_q, state_d;
    logic [THR_W-1:0] cnt_q, tot;
    logic [1:0]       zrun_q;
    logic             eval;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CH_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:  if (en_i) state_d = CH_SYNC;
            CH_SYNC: begin
                if (!en_i)           state_d = CH_OFF;
                else if (ref_rise_i) state_d = CH_RUN;
            end
            CH_RUN:  if (!en_i) state_d = CH_OFF;
            default: state_d = CH_OFF;
        endcase
    end

    always_comb begin
        tot        = (mon_rise_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
        eval       = (state_q == CH_RUN) && en_i && ref_rise_i;
        meas_hit_o = eval && ((tot > hi_i) || (tot < lo_i));
        tmo_hit_o  = eval && (tot == '0) && (zrun_q != 2'd0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            zrun_q <= '0;
        end else begin
            if (ref_rise_i || state_q == CH_OFF) cnt_q <= '0;
            else                                 cnt_q <= tot;
            if (state_q != CH_RUN) begin
                zrun_q <= '0;
            end else if (eval) begin
                if (tot != '0)           zrun_q <= '0;
                else if (zrun_q != 2'd2) zrun_q <= zrun_q + 2'd1;
            end
        end
    end

    // R2
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> (!meas_hit_o && !tmo_hit_o));

    // R10
    sync_no_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != CH_RUN) |-> (!meas_hit_o && !tmo_hit_o));

    // R6
    tmo_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_hit_o |-> ref_rise_i);
endmodule

// File: rtl/clkmeas_regs.sv
module clkmeas_regs
    import clkmeas_pkg::*;
#(
    parameter int NUM_CLK = 2,
    parameter int THR_W   = 6,
    parameter int RATIO   = 16,
    parameter int AW      = 3
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_en_i,
    input  logic [AW-1:0]                   wr_addr_i,
    input  logic [31:0]                     wr_data_i,
    input  logic [AW-1:0]                   rd_addr_i,
    output logic [31:0]                     rd_data_o,
    input  logic [NUM_CLK-1:0]              meas_hit_i,
    input  logic [NUM_CLK-1:0]              tmo_hit_i,
    output logic [NUM_CLK-1:0]              en_dec_o,
    output logic [NUM_CLK-1:0][THR_W-1:0]   lo_o,
    output logic [NUM_CLK-1:0][THR_W-1:0]   hi_o,
    output logic                            alert_o
);
    localparam int EN_W  = 4 * NUM_CLK;
    localparam int ERR_W = 2 * NUM_CLK;
    localparam logic [AW-1:0] A_LOCK = AW'(ADDR_LOCK);
    localparam logic [AW-1:0] A_EN   = AW'(ADDR_EN);
    localparam logic [AW-1:0] A_ERR  = AW'(ADDR_ERR);
    localparam logic [AW-1:0] A_THR0 = AW'(ADDR_THR0);
    localparam logic [THR_W-1:0] HI_RST = THR_W'(RATIO + 10);
    localparam logic [THR_W-1:0] LO_RST = THR_W'(RATIO - 10);

    logic                          lock_q;
    logic [EN_W-1:0]               en_q;
    logic [ERR_W-1:0]              err_q, err_clr;
    logic [NUM_CLK-1:0][THR_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lock_q <= 1'b1;
            en_q   <= {NUM_CLK{MB_FALSE}};
            for (int i = 0; i < NUM_CLK; i++) begin
                lo_q[i] <= LO_RST;
                hi_q[i] <= HI_RST;
            end
        end else if (wr_en_i) begin
            if (wr_addr_i == A_LOCK && !wr_data_i[0]) lock_q <= 1'b0;
            if (lock_q && wr_addr_i == A_EN) en_q <= wr_data_i[EN_W-1:0];
            for (int i = 0; i < NUM_CLK; i++) begin
                if (lock_q && wr_addr_i == A_THR0 + AW'(i)) begin
                    hi_q[i] <= wr_data_i[THR_W-1:0];
                    lo_q[i] <= wr_data_i[2*THR_W-1:THR_W];
                end
            end
        end
    end

    assign err_clr = (wr_en_i && wr_addr_i == A_ERR) ? wr_data_i[ERR_W-1:0] : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) err_q <= '0;
        else         err_q <= (err_q & ~err_clr) | {tmo_hit_i, meas_hit_i};
    end

    generate
        for (genvar g = 0; g < NUM_CLK; g++) begin : g_dec
            assign en_dec_o[g] = (en_q[4*g +: 4] == MB_TRUE);
        end
    endgenerate

    assign lo_o    = lo_q;
    assign hi_o    = hi_q;
    assign alert_o = |err_q;

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == A_LOCK)     rd_data_o[0] = lock_q;
        else if (rd_addr_i == A_EN)  rd_data_o[EN_W-1:0] = en_q;
        else if (rd_addr_i == A_ERR) rd_data_o[ERR_W-1:0] = err_q;
        else begin
            for (int i = 0; i < NUM_CLK; i++) begin
                if (rd_addr_i == A_THR0 + AW'(i))
                    rd_data_o[2*THR_W-1:0] = {lo_q[i], hi_q[i]};
            end
        end
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i == A_ERR) |=> ((err_q & $past(err_q)) == $past(err_q)));

    // R9
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_q |=> !lock_q);

    // R9
    lock_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_q |=> ($stable(en_q) && $stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/clkmeas_top.sv
module clkmeas_top
    import clkmeas_pkg::*;
#(
    parameter  int NUM_CLK = 2,
    parameter  int RATIO   = 16,
    localparam int THR_W   = $clog2(RATIO + 1) + 1,
    localparam int AW      = $clog2(ADDR_THR0 + NUM_CLK)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_CLK-1:0] mon_clk_i,
    input  logic               ref_clk_i,
    input  logic               wr_en_i,
    input  logic [AW-1:0]      wr_addr_i,
    input  logic [31:0]        wr_data_i,
    input  logic [AW-1:0]      rd_addr_i,
    output logic [31:0]        rd_data_o,
    output logic               alert_o
);
    logic                          ref_rise;
    logic [NUM_CLK-1:0]            mon_rise, meas_hit, tmo_hit, en_dec;
    logic [NUM_CLK-1:0][THR_W-1:0] lo, hi;

    clkmeas_edge u_ref_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(ref_clk_i),
        .rise_o (ref_rise)
    );

    generate
        for (genvar g = 0; g < NUM_CLK; g++) begin : g_ch
            clkmeas_edge u_mon_edge (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .async_i(mon_clk_i[g]),
                .rise_o (mon_rise[g])
            );
            clkmeas_chan #(.THR_W(THR_W)) u_chan (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .en_i      (en_dec[g]),
                .lo_i      (lo[g]),
                .hi_i      (hi[g]),
                .mon_rise_i(mon_rise[g]),
                .ref_rise_i(ref_rise),
                .meas_hit_o(meas_hit[g]),
                .tmo_hit_o (tmo_hit[g])
            );
        end
    endgenerate

    clkmeas_regs #(
        .NUM_CLK(NUM_CLK),
        .THR_W  (THR_W),
        .RATIO  (RATIO),
        .AW     (AW)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .meas_hit_i(meas_hit),
        .tmo_hit_i (tmo_hit),
        .en_dec_o  (en_dec),
        .lo_o      (lo),
        .hi_o      (hi),
        .alert_o   (alert_o)
    );

    // R8
    alert_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(alert_o) |-> $past(|{meas_hit, tmo_hit}));
endmodule

// File: tb/sim_clkmeas_top.sv
module sim_clkmeas_top;
    localparam int NUM   = 2;
    localparam int RATIO = 16;
    localparam int W     = $clog2(RATIO + 1) + 1;
    localparam int AW    = $clog2(3 + NUM);
    localparam int MAXC  = (1 << W) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NUM-1:0] mon = '0;
    logic           refc = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [31:0]    rd_data;
    logic           alert;

    int vectors = 0, misses = 0;
    int lo_m[NUM], hi_m[NUM], zr_m[NUM];
    bit run_m[NUM], en_m[NUM];
    logic [31:0] err_m = '0;
    logic [31:0] v;

    always #4 clk = ~clk;

    clkmeas_top #(.NUM_CLK(NUM), .RATIO(RATIO)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .mon_clk_i(mon), .ref_clk_i(refc),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .alert_o(alert)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = AW'(a);
        #1 d = rd_data;
    endtask

    function automatic logic [31:0] thr_word(input int lo, input int hi);
        return 32'((lo << W) | hi);
    endfunction

    task automatic set_en(input logic [3:0] e0, input logic [3:0] e1);
        wr(1, {24'd0, e1, e0});
        en_m[0] = (e0 == 4'b0110); en_m[1] = (e1 == 4'b0110);
        for (int c = 0; c < NUM; c++) if (!en_m[c]) begin run_m[c] = 0; zr_m[c] = 0; end
    endtask

    task automatic window(input int n0, input int n1);
        int nmax, n[NUM], t;
        n[0] = n0; n[1] = n1;
        nmax = (n0 > n1) ? n0 : n1;
        for (int k = 0; k < nmax; k++) begin
            @(negedge clk); mon[0] = (k < n0); mon[1] = (k < n1);
            @(negedge clk); @(negedge clk); mon = '0; @(negedge clk);
        end
        @(negedge clk); refc = 1'b1;
        @(negedge clk); @(negedge clk); refc = 1'b0;
        repeat (5) @(negedge clk);
        for (int c = 0; c < NUM; c++) begin
            if (run_m[c]) begin
                t = (n[c] > MAXC) ? MAXC : n[c];
                if (t > hi_m[c] || t < lo_m[c]) err_m[c] = 1'b1;
                if (t == 0) begin
                    if (zr_m[c] >= 1) err_m[NUM + c] = 1'b1;
                    zr_m[c] = (zr_m[c] >= 2) ? 2 : zr_m[c] + 1;
                end else zr_m[c] = 0;
            end else if (en_m[c]) run_m[c] = 1;
        end
    endtask

    task automatic check_err(input string tag);
        rd(2, v);
        check(tag, v, err_m);
        check({tag, " alert R8"}, {31'd0, alert}, {31'd0, (err_m != 0)});
    endtask

    task automatic clear_all();
        wr(2, 32'hFFFF_FFFF);
        err_m = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < NUM; c++) begin
            lo_m[c] = RATIO - 10; hi_m[c] = RATIO + 10; zr_m[c] = 0; run_m[c] = 0; en_m[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(0, v); check("R1 lock reset", v, 32'd1);
        rd(1, v); check("R1 enable reset", v, 32'h99);
        rd(2, v); check("R1 error reset", v, 32'd0);
        rd(3, v); check("R1 thr0 reset", v, thr_word(RATIO - 10, RATIO + 10));
        rd(4, v); check("R1 thr1 reset", v, thr_word(RATIO - 10, RATIO + 10));
        check("R1 alert reset", {31'd0, alert}, 32'd0);

        wr(4, thr_word(10, 20)); lo_m[1] = 10; hi_m[1] = 20;
        rd(4, v); check("R9 thr write while unlocked", v, thr_word(10, 20));
        set_en(4'b0110, 4'b0110);

        window(0, 40); check_err("R10 partial window ignored");
        window(16, 15); check_err("R3 nominal count");
        window(6, 10);  check_err("R3 count equals low");
        window(26, 20); check_err("R3 count equals high");
        window(27, 15); check_err("R4 count above high");
        window(16, 9);  check_err("R5 count below low");
        wr(2, 32'd1); err_m[0] = 1'b0;
        check_err("R7 partial w1c");
        clear_all(); check_err("R7 full w1c");

        window(0, 15); check_err("R6 first zero window only meas");
        window(0, 15); check_err("R6 second zero window timeout");
        clear_all();
        window(16, 15); check_err("R6 nonzero resets run");
        window(0, 15); check_err("R6 zero after nonzero");
        clear_all();

        wr(4, thr_word(10, 62)); lo_m[1] = 10; hi_m[1] = 62;
        window(16, 70); check_err("R11 saturated count above 62");
        clear_all();
        wr(4, thr_word(10, 63)); hi_m[1] = 63;
        window(16, 70); check_err("R11 saturated count equals 63");

        set_en(4'b0111, 4'b0110);
        window(40, 15); check_err("R2 invalid enable no check");
        window(0, 15);  check_err("R2 invalid enable no timeout");
        set_en(4'b0110, 4'b0110);
        window(40, 15); check_err("R10 re-enable partial window");

        wr(4, thr_word(10, 20)); hi_m[1] = 20;
        for (int it = 0; it < 30; it++) begin
            int a = $urandom_range(35, 0);
            int b = $urandom_range(35, 0);
            window(a, b);
            check_err("R3 R4 R5 R6 random window");
            if (it % 3 == 2) clear_all();
        end
        clear_all();

        wr(0, 32'd1); rd(0, v); check("R9 write 1 keeps lock", v, 32'd1);
        wr(0, 32'd0); rd(0, v); check("R9 write 0 clears lock", v, 32'd0);
        wr(3, thr_word(1, 2)); rd(3, v); check("R9 thr frozen", v, thr_word(lo_m[0], hi_m[0]));
        wr(1, 32'h99); rd(1, v); check("R9 enable frozen", v, 32'h66);
        wr(0, 32'd1); rd(0, v); check("R9 lock not re-set", v, 32'd0);
        window(30, 15); check_err("R9 checking continues locked");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule